// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

The block drives one pulse-width-modulated output from an 8-bit up-counting timebase. Each timer step lasts four input clocks times a selectable prescale factor of 1, 4 or 16. The period register sets the step count at which the timer returns to zero. A 10-bit duty word sets how long the output stays high. The timer count is extended below by a 2-bit sub-count, so the duty word is compared at four times the timer's resolution.

Software writes the period, the upper 8 duty bits and a control byte through a single write port. The control byte holds the two low duty bits, the prescale selection and the two enables. The duty word in use is a shadow copy that is refreshed only when a period ends or when PWM mode is switched on. Software can therefore change the duty word at any time without producing a short or long pulse. The shadow copy can be read on its own output.

Top module: `pwm_gen`

## Requirements
- R1: After reset, and until PWM mode is enabled, `pwm_o` is low and `shadow_duty_o` is 0.
- R2: A write with `wr_en_i` high updates one register, chosen by `wr_addr_i`:
  - address 0 loads the period P;
  - address 1 loads duty bits 9:2;
  - address 2 loads the control byte: bits 1:0 are duty bits 1:0, bits 3:2 are the prescale code, bit 4 is the timer enable and bit 5 is the PWM enable.
- R3: The prescale code selects the factor PS: 00 gives PS = 1, 01 gives PS = 4, and 10 or 11 gives PS = 16. The output repeats every 4·(P+1)·PS clocks.
- R4: For a duty word D with 0 < D < 4·(P+1), `pwm_o` is high for exactly D·PS clocks in each period. It rises one clock after the timer returns to zero.
- R5: Writes to the duty bits do not change `shadow_duty_o` or the current pulse. The new word takes effect at the next period end.
- R6: A shadow duty of 0 keeps `pwm_o` low for the whole period.
- R7: A shadow duty of at least 4·(P+1) keeps `pwm_o` high for the whole period.
- R8: While the timer enable is 0, the timer and sub-count freeze. `pwm_o` holds its level and `shadow_duty_o` holds its value.
- R9: While the PWM enable is 0, `pwm_o` is low. Raising the PWM enable restarts the timebase from zero and loads the shadow duty, so the first pulse already uses the latest duty word.
- R10: A period write below the current timer value lets the timer count on through 255 and wrap to 0 without ending the period. The period ends at the next match, and `pwm_o` does not rise at the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |
| shadow_duty_o | output | 10 | Duty word currently in use |

## Verification
The assertions assume that reset is applied first. They also assume that a period end happens only when the timer steps while it equals the period register, so that a rising output always follows a zero extended count. The stimulus switches PWM mode off before each new configuration and on again afterwards, so every measurement starts from a known restart of the timebase. The one exception is the wrap test, which rewrites the period mid-run on purpose, while the timer is above the new value and below the old one.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  typedef enum logic [1:0] {
    PS_1  = 2'b00,
    PS_4  = 2'b01,
    PS_16 = 2'b10,
    PS_16B = 2'b11
  } ps_sel_e;

  localparam int ADDR_PERIOD  = 0;
  localparam int ADDR_DUTY_HI = 1;
  localparam int ADDR_CTRL    = 2;

  // control byte layout
  localparam int CTRL_DLO_LSB = 0;
  localparam int CTRL_PS_LSB  = 2;
  localparam int CTRL_TEN_BIT = 4;
  localparam int CTRL_PEN_BIT = 5;

  // largest prescale shift: 16 = 2**4
  localparam int PS_SHIFT_MAX = 4;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int ADDR_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [TMR_W-1:0]        wr_data_i,
  output logic [TMR_W-1:0]        period_o,
  output logic [TMR_W+FRAC_W-1:0] duty_o,
  output ps_sel_e                 ps_o,
  output logic                    tmr_en_o,
  output logic                    pwm_en_o
);
  logic [TMR_W-1:0]  duty_hi_q;
  logic [FRAC_W-1:0] duty_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      ps_o      <= PS_1;
      tmr_en_o  <= 1'b0;
      pwm_en_o  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_PERIOD))  period_o  <= wr_data_i;
      if (wr_addr_i == ADDR_W'(ADDR_DUTY_HI)) duty_hi_q <= wr_data_i;
      if (wr_addr_i == ADDR_W'(ADDR_CTRL)) begin
        duty_lo_q <= wr_data_i[CTRL_DLO_LSB +: FRAC_W];
        ps_o      <= ps_sel_e'(wr_data_i[CTRL_PS_LSB +: 2]);
        tmr_en_o  <= wr_data_i[CTRL_TEN_BIT];
        pwm_en_o  <= wr_data_i[CTRL_PEN_BIT];
      end
    end
  end

  assign duty_o = {duty_hi_q, duty_lo_q};
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    restart_i,
  input  logic [TMR_W-1:0]        period_i,
  input  ps_sel_e                 ps_i,
  output logic [TMR_W+FRAC_W-1:0] ext_o,
  output logic                    roll_o
);
  localparam int DIV_W = FRAC_W + PS_SHIFT_MAX;

  logic [DIV_W-1:0]  div_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [2:0]        sh;
  logic [DIV_W-1:0]  term;
  logic [FRAC_W-1:0] sub;
  logic              div_end, step;

  always_comb begin
    case (ps_i)
      PS_1:    sh = 3'd0;
      PS_4:    sh = 3'd2;
      default: sh = 3'd4;
    endcase
  end

  // one timer step spans 2**(FRAC_W+sh) clocks
  assign term    = {DIV_W{1'b1}} >> (PS_SHIFT_MAX - int'(sh));
  assign sub     = FRAC_W'(div_q >> sh);
  assign div_end = (div_q >= term);
  assign step    = en_i && div_end;
  assign roll_o  = step && (tmr_q == period_i);
  assign ext_o   = {tmr_q, sub};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      tmr_q <= '0;
    end else if (restart_i) begin
      div_q <= '0;
      tmr_q <= '0;
    end else if (en_i) begin
      div_q <= div_end ? '0 : div_q + 1'b1;
      if (step) tmr_q <= roll_o ? '0 : tmr_q + 1'b1;
    end
  end

  assert_tmr_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> ($stable(tmr_q) && $stable(div_q)));

  assert_tmr_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q != $past(tmr_q)) |-> ((tmr_q == TMR_W'($past(tmr_q) + 1'b1)) || (tmr_q == '0)));
endmodule

// File: rtl/pwm_duty.sv
`timescale 1ns/1ps
module pwm_duty #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    roll_i,
  input  logic [TMR_W+FRAC_W-1:0] duty_i,
  input  logic [TMR_W+FRAC_W-1:0] ext_i,
  output logic                    start_o,
  output logic                    pwm_o,
  output logic [TMR_W+FRAC_W-1:0] shadow_o
);
  localparam int EXT_W = TMR_W + FRAC_W;

  logic [EXT_W-1:0] shadow_q;
  logic             en_d_q, active_q, pwm_q, below;

  assign start_o = en_i && !en_d_q;
  assign below   = (ext_i < shadow_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      en_d_q   <= 1'b0;
      active_q <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      en_d_q <= en_i;
      if (start_o || roll_i) begin
        shadow_q <= duty_i;
        active_q <= 1'b1;
      end else if (!below) begin
        active_q <= 1'b0;   // stays low across a free wrap of the timer
      end
      pwm_q <= en_d_q && active_q && below;
    end
  end

  assign pwm_o    = pwm_q;
  assign shadow_o = shadow_q;

  assert_shadow_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o || roll_i) |=> $stable(shadow_q));

  assert_zero_duty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_q == '0) |=> !pwm_q);

  assert_disabled_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_d_q |=> !pwm_q);

  assert_rise_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> ($past(ext_i) == '0));
endmodule

// File: rtl/pwm_gen.sv
`timescale 1ns/1ps
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int ADDR_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [TMR_W-1:0]        wr_data_i,
  output logic                    pwm_o,
  output logic [TMR_W+FRAC_W-1:0] shadow_duty_o
);
  localparam int EXT_W = TMR_W + FRAC_W;

  logic [TMR_W-1:0] period;
  logic [EXT_W-1:0] duty, ext;
  ps_sel_e          ps;
  logic             tmr_en, pwm_en, roll, start;

  pwm_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .period_o  (period),
    .duty_o    (duty),
    .ps_o      (ps),
    .tmr_en_o  (tmr_en),
    .pwm_en_o  (pwm_en)
  );

  pwm_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tmr_en),
    .restart_i (start),
    .period_i  (period),
    .ps_i      (ps),
    .ext_o     (ext),
    .roll_o    (roll)
  );

  pwm_duty #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pwm_en),
    .roll_i   (roll),
    .duty_i   (duty),
    .ext_i    (ext),
    .start_o  (start),
    .pwm_o    (pwm_o),
    .shadow_o (shadow_duty_o)
  );
endmodule

// File: tb/pwm_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm;
  logic [9:0] shadow;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [1:0]  ps;
    logic [7:0]  per;
    logic [9:0]  duty;
    logic [15:0] hi;
    logic [15:0] prd;
  } vec_t;

  // expected: prd = 4*(P+1)*PS, hi = PS*min(D, 4*(P+1))
  localparam vec_t VEC [8] = '{
    '{2'd0, 8'd9, 10'd20,  16'd20, 16'd40},   // R3 R4
    '{2'd1, 8'd4, 10'd7,   16'd28, 16'd80},   // R3 R4
    '{2'd2, 8'd2, 10'd5,   16'd80, 16'd192},  // R3 R4
    '{2'd0, 8'd3, 10'd100, 16'd16, 16'd16},   // R7
    '{2'd0, 8'd7, 10'd0,   16'd0,  16'd32},   // R6
    '{2'd0, 8'd7, 10'd31,  16'd31, 16'd32},   // R4
    '{2'd1, 8'd0, 10'd1,   16'd4,  16'd16},   // R4
    '{2'd3, 8'd1, 10'd6,   16'd96, 16'd128}   // R3 R4
  };

  pwm_gen dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .pwm_o         (pwm),
    .shadow_duty_o (shadow)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input logic [1:0] ps, input logic [1:0] dlo,
                                      input logic ten, input logic pen);
    return {2'b00, pen, ten, ps, dlo};
  endfunction

  task automatic cfg(input logic [1:0] ps, input logic [7:0] per, input logic [9:0] d,
                     input logic ten, input logic pen);
    wr(2'd0, per);
    wr(2'd1, d[9:2]);
    wr(2'd2, ctrl(ps, d[1:0], ten, pen));
  endtask

  task automatic count_hi(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm) h++;
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = pwm;
    forever begin
      @(negedge clk);
      if (pwm && !p) break;
      p = pwm;
    end
  endtask

  task automatic measure(output int gap, output int h);
    logic p;
    wait_rise();
    gap = 0; h = 0;
    forever begin
      gap++;
      if (pwm) h++;
      p = pwm;
      @(negedge clk);
      if (pwm && !p) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, g, t1, lvl, mism;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm), 0);
    chk("R1 shadow in reset", int'(shadow), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 pwm after reset", int'(pwm), 0);

    // vector table: R2 R3 R4 R6 R7
    for (int i = 0; i < 8; i++) begin
      cfg(VEC[i].ps, VEC[i].per, VEC[i].duty, 1'b1, 1'b0);
      wr(2'd2, ctrl(VEC[i].ps, VEC[i].duty[1:0], 1'b1, 1'b1));
      repeat (2 * int'(VEC[i].prd) + 8) @(negedge clk);
      chk($sformatf("R2 shadow vec%0d", i), int'(shadow), int'(VEC[i].duty));
      count_hi(2 * int'(VEC[i].prd), h);
      chk($sformatf("R4 R6 R7 high vec%0d", i), h, 2 * int'(VEC[i].hi));
      if (VEC[i].hi != 0 && VEC[i].hi != VEC[i].prd) begin
        measure(g, h);
        chk($sformatf("R3 period vec%0d", i), g, int'(VEC[i].prd));
        chk($sformatf("R4 pulse vec%0d", i), h, int'(VEC[i].hi));
      end
    end

    // R5 double buffering: P=9, PS=1, D=20 then 32 mid-period
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b1, 1'b0));
    cfg(2'd0, 8'd9, 10'd20, 1'b1, 1'b1);
    repeat (15) @(negedge clk);
    wr(2'd1, 8'd8);
    chk("R5 shadow held after write", int'(shadow), 20);
    repeat (45) @(negedge clk);
    chk("R5 shadow after rollover", int'(shadow), 32);
    count_hi(80, h);
    chk("R5 new duty in effect", h, 64);

    // R8 freeze while high
    wait_rise();
    repeat (5) @(negedge clk);
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b0, 1'b1));
    repeat (2) @(negedge clk);
    lvl = int'(pwm);
    chk("R8 level at freeze", lvl, 1);
    wr(2'd1, 8'd1);
    mism = 0;
    repeat (100) begin
      @(negedge clk);
      if (int'(pwm) != lvl) mism++;
    end
    chk("R8 output held", mism, 0);
    chk("R8 shadow held", int'(shadow), 32);

    // R9 disabled output low, then start loads latest duty
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    count_hi(100, h);
    chk("R9 low while disabled", h, 0);
    wr(2'd1, 8'd3);
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    chk("R9 shadow loaded at start", int'(shadow), 12);
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b1, 1'b0));
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b1, 1'b1));
    measure(g, h);
    chk("R9 first pulse width", h, 12);
    chk("R9 first period", g, 40);

    // R10 period lowered below timer: wrap through 255 before matching
    wr(2'd2, ctrl(2'd0, 2'd0, 1'b1, 1'b0));
    cfg(2'd0, 8'd200, 10'd8, 1'b1, 1'b1);
    wait_rise();
    t1 = cyc;
    repeat (400) @(negedge clk);
    wr(2'd0, 8'd50);
    wait_rise();
    chk("R10 gap across wrap", cyc - t1, 1228);
    measure(g, h);
    chk("R10 new period", g, 204);
    chk("R10 pulse after wrap", h, 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule